// File: doc/BRIEF.md
# Serial DAC Interface Controller

This block is the digital front end of a 12-bit or 14-bit straight-binary converter. A host sends 16-bit words, most significant bit first, on a three-wire serial link: a serial clock, an active-low frame select and a data line. Each bit is sampled on a falling clock edge while the frame select is low. The block keeps the word in a shift register and moves its data field into a converter register. This happens either at the end of the frame or later, on an active-low load strobe. Which of the two applies is decided per frame, from the level of the strobe when the frame opens.

The serial output is modelled as open-drain. Outside readback it repeats each written bit sixteen falling edges later, so several blocks can be chained. When the readback enable falls, the next clock fall copies the converter register into the shift register, and the code is then shifted out. An active-low clear pin forces the output code to a fixed clear level and leaves both registers intact. A power-down pin raises a low-power flag. Every pin passes through a two-flop synchroniser into the system clock domain, and all edges are detected on the synchronised values.

Top module: `serdac_front`

## Requirements
- R1: After reset the shift and converter registers are zero, `code_o` is 0, `cleared_o` is 0 and `sdo_pull_o` is 0 (line released).
- R2: A frame is 16 falling edges of `sclk_i` while `sync_n_i` is low, MSB first. The code comes from word bits 13..0 when DATA_W is 14, and from bits 13..2 when DATA_W is 12. Word bits 15..14 (and 1..0 at 12 bits) are ignored.
- R3: If `load_n_i` is low when `sync_n_i` falls, the converter register takes the frame's code when `sync_n_i` rises, and not while `sync_n_i` stays low.
- R4: If `load_n_i` is high when `sync_n_i` falls, the frame end leaves the converter register unchanged. The frame's code moves in once `load_n_i` is low while `sync_n_i` is high.
- R5: A frame that ends after fewer than 16 falling edges changes nothing, including through a later load strobe.
- R6: A fall of `rdbk_n_i` arms readback. The next `sclk_i` fall loads the word {2'b00, code, zero pad to 14 bits}, and its bit 15 appears on the serial output at once. Each later fall while `rdbk_n_i` is low presents the next bit.
- R7: Outside readback, the serial output after a falling edge within a frame equals the bit written 16 falling edges earlier.
- R8: `sdo_pull_o` is 1 (drive low) exactly when the output bit is 0, and 0 (released) when it is 1.
- R9: A fall of `clr_n_i` sets `cleared_o` and forces `code_o` to CLEAR_CODE (default 0). The converter register keeps its value and can still be written.
- R10: `cleared_o` drops, and `code_o` shows the register again, when `clr_n_i` is high and `load_n_i` is low. This happens on its own if the strobe is held low, or otherwise on a strobe pulse.
- R11: `pd_o` is the inverse of the synchronised `pdn_n_i` and has no effect on the converter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, data taken on falling edges |
| sync_n_i | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low converter load strobe |
| rdbk_n_i | input | 1 | Active-low readback enable |
| clr_n_i | input | 1 | Active-low clear |
| pdn_n_i | input | 1 | Active-low power-down request |
| sdo_pull_o | output | 1 | Open-drain enable: 1 pulls serial output low |
| code_o | output | DATA_W | Active converter code |
| cleared_o | output | 1 | Output forced to clear level |
| pd_o | output | 1 | Low-power flag |

## Verification
The assertions assume that every pin holds still for several system clocks around each change. In particular, a `sync_n_i` or `rdbk_n_i` edge never lands in the same synchronised cycle as an `sclk_i` fall, and readback is only run with the frame select high. The stimulus keeps to this: it changes one pin per task and holds each serial clock phase for seven system clocks. It opens and closes frames only while the serial clock is high. It does not strobe a pending load after a readback has rewritten the shift register.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
    localparam int FRAME_W  = 16;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int FIELD_HI = FRAME_W - 3;

    // edge-detected pin group
    localparam int E_SCLK = 0;
    localparam int E_SYNC = 1;
    localparam int E_RDBK = 2;
    localparam int E_CLR  = 3;
    localparam int E_NUM  = 4;

    // level-only pin group
    localparam int L_SDIN = 0;
    localparam int L_LOAD = 1;
    localparam int L_PDN  = 2;
    localparam int L_NUM  = 3;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               sdo;
        logic               arm;
    } shift_st_t;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{IDLE}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serdac_edge.sv
module serdac_edge #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prv_o
);
    logic [W-1:0] lvl;
    logic [W-1:0] prv_d, prv_q;

    serdac_sync #(.W(W), .STAGES(STAGES), .IDLE(IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .lvl_o (lvl)
    );

    always_comb begin
        prv_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_q <= IDLE;
        end else begin
            prv_q <= prv_d;
        end
    end

    assign lvl_o = lvl;
    assign prv_o = prv_q;
endmodule

// File: rtl/serdac_shift.sv
module serdac_shift
    import serdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_fall,
    input  logic               sync_lvl,
    input  logic               sync_fall,
    input  logic               rdbk_lvl,
    input  logic               rdbk_fall,
    input  logic               rdbk_rise,
    input  logic               sdin_lvl,
    input  logic [FRAME_W-1:0] rb_word,
    output logic [FRAME_W-1:0] frame_o,
    output logic               full_o,
    output logic               rb_load_o,
    output logic               sdo_pull_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    shift_st_t st_d, st_q;
    logic      rb_load;

    always_comb begin
        st_d    = st_q;
        rb_load = sclk_fall && st_q.arm;

        if (rdbk_fall) begin
            st_d.arm = 1'b1;
        end else if (rdbk_rise) begin
            st_d.arm = 1'b0;
        end

        if (sync_fall) begin
            st_d.cnt = '0;
        end

        if (rb_load) begin
            st_d.sr  = {rb_word[FRAME_W-2:0], 1'b0};
            st_d.sdo = rb_word[FRAME_W-1];
            st_d.arm = 1'b0;
        end else if (sclk_fall && (!sync_lvl || !rdbk_lvl)) begin
            st_d.sdo = st_q.sr[FRAME_W-1];
            st_d.sr  = {st_q.sr[FRAME_W-2:0], sdin_lvl};
            if (!sync_lvl && st_q.cnt != CNT_FULL) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr  <= '0;
            st_q.cnt <= '0;
            st_q.sdo <= 1'b1;
            st_q.arm <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o    = st_q.sr;
    assign full_o     = (st_q.cnt == CNT_FULL);
    assign rb_load_o  = rb_load;
    assign sdo_pull_o = ~st_q.sdo;
endmodule

// File: rtl/serdac_load.sv
module serdac_load #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_fall,
    input  logic              sync_rise,
    input  logic              sync_lvl,
    input  logic              load_lvl,
    input  logic              clr_fall,
    input  logic              clr_lvl,
    input  logic              full,
    input  logic [DATA_W-1:0] field,
    output logic [DATA_W-1:0] dac_o,
    output logic              cleared_o
);
    typedef struct packed {
        logic [DATA_W-1:0] dac;
        logic              auto_ld;
        logic              pend;
        logic              clr;
    } load_st_t;

    load_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (sync_fall) begin
            st_d.auto_ld = !load_lvl;
            st_d.pend    = 1'b0;
        end

        if (sync_rise && full) begin
            if (st_q.auto_ld) begin
                st_d.dac = field;
            end else begin
                st_d.pend = 1'b1;
            end
        end

        if (st_q.pend && !load_lvl && sync_lvl) begin
            st_d.dac  = field;
            st_d.pend = 1'b0;
        end

        if (clr_fall) begin
            st_d.clr = 1'b1;
        end else if (st_q.clr && clr_lvl && !load_lvl) begin
            st_d.clr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_o     = st_q.dac;
    assign cleared_o = st_q.clr;
endmodule

// File: rtl/serdac_front.sv
module serdac_front
    import serdac_pkg::*;
#(
    parameter int                DATA_W     = 14,
    parameter int                SYNC_STG   = 2,
    parameter logic [DATA_W-1:0] CLEAR_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              sdin_i,
    input  logic              load_n_i,
    input  logic              rdbk_n_i,
    input  logic              clr_n_i,
    input  logic              pdn_n_i,
    output logic              sdo_pull_o,
    output logic [DATA_W-1:0] code_o,
    output logic              cleared_o,
    output logic              pd_o
);
    localparam int PAD = FIELD_HI + 1 - DATA_W;

    logic [E_NUM-1:0]   e_pin, e_lvl, e_prv;
    logic [L_NUM-1:0]   l_pin, l_lvl;
    logic               sclk_fall, sync_fall, sync_rise, rdbk_fall, rdbk_rise;
    logic               sync_lvl, rdbk_lvl, clr_lvl, clr_fall, load_lvl;
    logic               frame_full, rb_load;
    logic [FRAME_W-1:0] frame, rb_word;
    logic [DATA_W-1:0]  dac_code;

    assign e_pin[E_SCLK] = sclk_i;
    assign e_pin[E_SYNC] = sync_n_i;
    assign e_pin[E_RDBK] = rdbk_n_i;
    assign e_pin[E_CLR]  = clr_n_i;
    assign l_pin[L_SDIN] = sdin_i;
    assign l_pin[L_LOAD] = load_n_i;
    assign l_pin[L_PDN]  = pdn_n_i;

    serdac_edge #(.W(E_NUM), .STAGES(SYNC_STG), .IDLE('1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (e_pin),
        .lvl_o (e_lvl),
        .prv_o (e_prv)
    );

    serdac_sync #(.W(L_NUM), .STAGES(SYNC_STG), .IDLE(3'b110)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (l_pin),
        .lvl_o (l_lvl)
    );

    assign sclk_fall = e_prv[E_SCLK] & ~e_lvl[E_SCLK];
    assign sync_fall = e_prv[E_SYNC] & ~e_lvl[E_SYNC];
    assign sync_rise = ~e_prv[E_SYNC] & e_lvl[E_SYNC];
    assign rdbk_fall = e_prv[E_RDBK] & ~e_lvl[E_RDBK];
    assign rdbk_rise = ~e_prv[E_RDBK] & e_lvl[E_RDBK];
    assign clr_fall  = e_prv[E_CLR] & ~e_lvl[E_CLR];
    assign sync_lvl  = e_lvl[E_SYNC];
    assign rdbk_lvl  = e_lvl[E_RDBK];
    assign clr_lvl   = e_lvl[E_CLR];
    assign load_lvl  = l_lvl[L_LOAD];

    generate
        if (PAD == 0) begin : g_rb_full
            assign rb_word = {2'b00, dac_code};
        end else begin : g_rb_pad
            assign rb_word = {2'b00, dac_code, {PAD{1'b0}}};
        end
    endgenerate

    serdac_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .sync_lvl   (sync_lvl),
        .sync_fall  (sync_fall),
        .rdbk_lvl   (rdbk_lvl),
        .rdbk_fall  (rdbk_fall),
        .rdbk_rise  (rdbk_rise),
        .sdin_lvl   (l_lvl[L_SDIN]),
        .rb_word    (rb_word),
        .frame_o    (frame),
        .full_o     (frame_full),
        .rb_load_o  (rb_load),
        .sdo_pull_o (sdo_pull_o)
    );

    serdac_load #(.DATA_W(DATA_W)) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_fall (sync_fall),
        .sync_rise (sync_rise),
        .sync_lvl  (sync_lvl),
        .load_lvl  (load_lvl),
        .clr_fall  (clr_fall),
        .clr_lvl   (clr_lvl),
        .full      (frame_full),
        .field     (frame[FIELD_HI -: DATA_W]),
        .dac_o     (dac_code),
        .cleared_o (cleared_o)
    );

    assign code_o = cleared_o ? CLEAR_CODE : dac_code;
    assign pd_o   = ~l_lvl[L_PDN];
endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk #(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_lvl,
    input logic              sync_rise,
    input logic              frame_full,
    input logic              clr_fall,
    input logic              clr_lvl,
    input logic              load_lvl,
    input logic              rb_load,
    input logic              sdo_pull,
    input logic              cleared,
    input logic [DATA_W-1:0] dac
);
    // R3: no converter update while a frame is open
    a_r3_frame_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_lvl |=> $stable(dac));

    // R5: a short frame leaves the converter register alone
    a_r5_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rise && !frame_full) |=> $stable(dac));

    // R6: the readback word starts with a zero bit on the line
    a_r6_rb_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rb_load |=> sdo_pull);

    // R9: a clear edge sets the cleared state
    a_r9_clear_sets: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> cleared);

    // R10: clear high with strobe low releases the clear
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cleared && clr_lvl && !load_lvl) |=> !cleared);
endmodule

bind serdac_front serdac_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_lvl   (sync_lvl),
    .sync_rise  (sync_rise),
    .frame_full (frame_full),
    .clr_fall   (clr_fall),
    .clr_lvl    (clr_lvl),
    .load_lvl   (load_lvl),
    .rb_load    (rb_load),
    .sdo_pull   (sdo_pull_o),
    .cleared    (cleared_o),
    .dac        (dac_code)
);

// File: tb/serdac_front_test.sv
module serdac_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 7;
    localparam int SETTLE     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, load_n = 1'b1;
    logic rdbk_n = 1'b1, clr_n = 1'b1, pdn_n = 1'b1;
    logic        sdo14, sdo12, clr14, clr12, pd14, pd12;
    logic [13:0] code14;
    logic [11:0] code12;

    always #(CLK_PERIOD/2) clk = ~clk;

    serdac_front #(.DATA_W(14)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
        .load_n_i(load_n), .rdbk_n_i(rdbk_n), .clr_n_i(clr_n), .pdn_n_i(pdn_n),
        .sdo_pull_o(sdo14), .code_o(code14), .cleared_o(clr14), .pd_o(pd14));

    serdac_front #(.DATA_W(12)) uut12 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
        .load_n_i(load_n), .rdbk_n_i(rdbk_n), .clr_n_i(clr_n), .pdn_n_i(pdn_n),
        .sdo_pull_o(sdo12), .code_o(code12), .cleared_o(clr12), .pd_o(pd12));

    // behavioural reference model
    logic [13:0] m_dac;
    logic [15:0] m_fw;
    logic        m_auto, m_pend, m_clr, m_arm, m_sdo;
    int          m_cnt;
    logic        m_q[$];

    int  checks = 0, fails = 0, quiet = 0;
    bit  done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_dac = '0; m_fw = '0; m_auto = 0; m_pend = 0; m_clr = 0; m_arm = 0;
        m_sdo = 1; m_cnt = 0;
        m_q.delete();
        for (int i = 0; i < 16; i++) m_q.push_back(1'b0);
    endfunction

    function automatic void m_apply();
        if (m_pend && !load_n && sync_n) begin
            m_dac = m_fw[13:0];
            m_pend = 0;
        end
        if (m_clr && clr_n && !load_n) m_clr = 0;
    endfunction

    function automatic void m_fall();
        logic [15:0] rb;
        if (m_arm) begin
            rb = {2'b00, m_dac};
            m_sdo = rb[15];
            m_q.delete();
            for (int i = 14; i >= 0; i--) m_q.push_back(rb[i]);
            m_q.push_back(1'b0);
            m_arm = 0;
        end else if (!sync_n || !rdbk_n) begin
            m_sdo = m_q.pop_front();
            m_q.push_back(sdin);
            if (!sync_n) begin
                if (m_cnt < 16) m_cnt++;
                m_fw = {m_fw[14:0], sdin};
            end
        end
    endfunction

    // per-clock comparison once the pins have settled
    always @(negedge clk) begin
        if (rst_n && !done && quiet >= SETTLE) begin
            check("R2/R9 code14", code14, m_clr ? 14'h0 : m_dac);
            check("R9 cleared", clr14, m_clr);
            check("R11 pd", pd14, !pdn_n);
            check("R7/R8 sdo", sdo14, !m_sdo);
        end
        quiet++;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_sync(input logic v);
        @(negedge clk);
        if (sync_n && !v) begin
            m_auto = !load_n; m_pend = 0; m_cnt = 0;
        end
        sync_n = v;
        if (v && m_cnt >= 16) begin
            if (m_auto) m_dac = m_fw[13:0];
            else m_pend = 1;
        end
        quiet = 0;
        m_apply();
    endtask

    task automatic drive_load(input logic v);
        @(negedge clk); load_n = v; quiet = 0; m_apply();
    endtask

    task automatic drive_clr(input logic v);
        @(negedge clk);
        if (clr_n && !v) m_clr = 1;
        clr_n = v; quiet = 0; m_apply();
    endtask

    task automatic drive_rdbk(input logic v);
        @(negedge clk);
        if (rdbk_n && !v) m_arm = 1;
        else if (!rdbk_n && v) m_arm = 0;
        rdbk_n = v; quiet = 0;
    endtask

    task automatic drive_pdn(input logic v);
        @(negedge clk); pdn_n = v; quiet = 0;
    endtask

    task automatic one_bit(input logic b, output logic o14, output logic o12);
        @(negedge clk); sdin = b; quiet = 0;
        wait_clk(HALF);
        sclk = 1'b0; m_fall(); quiet = 0;
        wait_clk(HALF);
        o14 = !sdo14; o12 = !sdo12;
        sclk = 1'b1; quiet = 0;
    endtask

    task automatic frame(input logic [15:0] w, input int nbits,
                         output logic [15:0] s14, output logic [15:0] s12);
        logic a, b;
        s14 = '0; s12 = '0;
        drive_sync(1'b0);
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            one_bit(w[15-i], a, b);
            s14 = {s14[14:0], a};
            s12 = {s12[14:0], b};
        end
        wait_clk(HALF);
        drive_sync(1'b1);
        wait_clk(3*HALF);
    endtask

    task automatic readback(output logic [15:0] s14, output logic [15:0] s12);
        logic a, b;
        s14 = '0; s12 = '0;
        drive_rdbk(1'b0);
        wait_clk(HALF);
        for (int i = 0; i < 16; i++) begin
            one_bit(1'b0, a, b);
            s14 = {s14[14:0], a};
            s12 = {s12[14:0], b};
        end
        drive_rdbk(1'b1);
        wait_clk(3*HALF);
    endtask

    task automatic pulse_load();
        drive_load(1'b0); wait_clk(2*HALF);
        drive_load(1'b1); wait_clk(2*HALF);
    endtask

    initial begin
        logic [15:0] s14, s12;
        m_reset();
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(10);
        check("R1 code", code14, 14'h0);
        check("R1 cleared", clr14, 1'b0);
        check("R1 sdo released", sdo14, 1'b0);
        check("R11 pd idle", pd14, 1'b0);

        // R3 + R2: automatic load at frame end
        drive_load(1'b0);
        frame(16'hABCD, 16, s14, s12);
        check("R3 code14", code14, 14'h2BCD);
        check("R2 code12 field", code12, 12'hAF3);

        // R4: strobe high at frame start, then a strobe pulse
        drive_load(1'b1);
        frame(16'hFFFF, 16, s14, s12);
        check("R4 held", code14, 14'h2BCD);
        pulse_load();
        check("R4 strobe load", code14, 14'h3FFF);
        check("R4 code12", code12, 12'hFFF);

        // R5: short frames are discarded
        drive_load(1'b0);
        frame(16'h0000, 10, s14, s12);
        check("R5 short auto", code14, 14'h3FFF);
        drive_load(1'b1);
        frame(16'h0000, 10, s14, s12);
        pulse_load();
        check("R5 short strobe", code14, 14'h3FFF);

        // R2: top bits ignored
        drive_load(1'b0);
        frame(16'hC001, 16, s14, s12);
        check("R2 top ignored", code14, 14'h0001);
        check("R2 code12 low ignored", code12, 12'h000);

        // R7/R8: daisy-chain output
        frame(16'h1234, 16, s14, s12);
        check("R3 code14 b", code14, 14'h1234);
        drive_load(1'b1);
        frame(16'h5678, 16, s14, s12);
        check("R7/R8 daisy word", s14, 16'h1234);
        check("R7 daisy word 12", s12, 16'h1234);
        pulse_load();
        check("R4 code14 c", code14, 14'h1678);
        check("R4 code12 c", code12, 12'h59E);

        // R6: readback
        readback(s14, s12);
        check("R6 readback14", s14, 16'h1678);
        check("R6 readback12", s12, 16'h1678);

        // R9/R10: clear with strobe pulse
        drive_clr(1'b0); wait_clk(2*HALF);
        check("R9 cleared", clr14, 1'b1);
        check("R9 forced code", code14, 14'h0);
        check("R9 forced code12", code12, 12'h0);
        drive_clr(1'b1); wait_clk(2*HALF);
        check("R10 stays without strobe", clr14, 1'b1);
        pulse_load();
        check("R10 released", clr14, 1'b0);
        check("R9 register kept", code14, 14'h1678);

        // R9/R10: strobe held low, write while cleared
        drive_load(1'b0);
        drive_clr(1'b0); wait_clk(2*HALF);
        frame(16'h0ABC, 16, s14, s12);
        check("R9 masked while written", code14, 14'h0);
        drive_clr(1'b1); wait_clk(2*HALF);
        check("R10 auto release", clr14, 1'b0);
        check("R10 new code", code14, 14'h0ABC);
        check("R10 new code12", code12, 12'h2AF);

        // R11: power-down flag
        drive_pdn(1'b0); wait_clk(2*HALF);
        check("R11 pd set", pd14, 1'b1);
        check("R11 code kept", code14, 14'h0ABC);
        drive_pdn(1'b1); wait_clk(2*HALF);
        check("R11 pd clear", pd14, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule